// File: doc/BRIEF.md
# Interrupt Source PQ Coalescing Bank

This block holds a two-bit event state for each of a set of interrupt sources. The two bits are P (pending) and Q (queued again). They make sure that a source is handed to the downstream event queue at most once until software acknowledges it. A hardware trigger on an idle source sets P and produces one notification that carries the source index. A trigger on a source whose P is already set only records Q. When software acknowledges the source with an end-of-interrupt (EOI), the block reads Q to decide whether to notify again.

Software reaches the state through a simple request/response port. Each source owns one 4 KB page. The page number selects the source, and the offset inside the page selects the operation. Every load returns the state held before the operation, and the read and the update happen in the same clock edge. Notifications leave on a valid/ready stream. A notification that has been offered keeps its index until the consumer takes it. The one exception is when software clears P first, which withdraws the notification. When several sources are waiting, a round-robin arbiter picks which one is offered next. The request port and the response have no back-pressure: a request is accepted in the cycle it is valid, and each load produces exactly one response in the next cycle.

Top module: `evt_pq_bank`

## Requirements
- R1: After reset every source holds PQ=00, `ntf_valid` is low and `rsp_valid` is low.
- R2: A trigger on a source with P=0 sets P=1 and leaves Q unchanged. The source then offers exactly one notification with its index on `ntf_idx`.
- R3: A trigger on a source with P=1 sets Q=1 and offers no notification.
- R4: An EOI is a load at offset 0x000 or a store at offset 0x400. An EOI on a source with Q=0 clears P, so PQ becomes 00, and offers no notification.
- R5: An EOI on a source with Q=1 clears Q, leaves P=1 (PQ=10) and offers one new notification.
- R6: Every load produces `rsp_valid` in the following cycle. The response carries the PQ held before the operation in bits [1:0], with P as value 0x2 and Q as value 0x1. All upper bits are zero.
- R7: A load at offset 0x800, or at any offset not listed in R4 or R8 (including 0x400), returns the current PQ and changes nothing.
- R8: A load at offset 0xC00, 0xD00, 0xE00 or 0xF00 sets PQ to 00, 01, 10 or 11 respectively, which is address bits [9:8]. It offers no notification.
- R9: Store data is ignored. A store at any offset other than 0x400 changes nothing, and no store produces a response.
- R10: When an operation from software and a trigger hit the same source in the same cycle, the operation is applied first and the trigger is applied to the result.
- R11: `ntf_idx` does not change while `ntf_valid` is high and `ntf_ready` is low. At most one notification is accepted per cycle. Sources waiting together are served in round-robin order, starting after the last accepted index.
- R12: The source index is taken from address bits [14:12]. A load to an index at or above the source count returns 0 and changes no state.
- R13: A notification not yet accepted is withdrawn when software leaves its source with P=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_trig | input | NSRC | Per-source trigger, one bit per source, sampled each cycle |
| mmio_valid | input | 1 | Request present; it is always accepted |
| mmio_write | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | IDX_W+12 | Source index in the page number bits, operation in offset bits [11:0] |
| mmio_wdata | input | DATA_W | Store data, ignored |
| rsp_valid | output | 1 | Load response, one cycle after the load |
| rsp_data | output | DATA_W | Previous PQ in bits [1:0], upper bits zero |
| ntf_valid | output | 1 | Notification offered |
| ntf_ready | input | 1 | Consumer accepts the offered notification |
| ntf_idx | output | IDX_W | Index of the notifying source |

## Verification
The assertions take the reset as synchronous and held low from time zero. They assume `src_trig` and the request pins are stable around the rising edge. They also assume that while a notification is held back, the only way it can vanish is that software clears P; the stability property is written to allow that one case. The stimulus drives every input on the falling edge. It withdraws a held notification only through a set-to-00 load. It never places a trigger and a request on the same source in the same cycle, except in the cases meant to test R10.

// File: rtl/evt_pq_pkg.sv
package evt_pq_pkg;

  localparam int PAGE_BITS = 12;
  localparam logic [11:0] OFF_LD_EOI = 12'h000;
  localparam logic [11:0] OFF_ST_EOI = 12'h400;
  localparam logic [11:0] OFF_GET    = 12'h800;

  typedef enum logic [1:0] {
    PQ_OP_NONE,
    PQ_OP_GET,
    PQ_OP_EOI,
    PQ_OP_SET
  } pq_op_e;

  typedef struct packed {
    pq_op_e     op;
    logic [1:0] set_val;
  } pq_cmd_t;

  function automatic pq_cmd_t pq_decode(input logic wr, input logic [11:0] off);
    pq_cmd_t c;
    c.op      = PQ_OP_NONE;
    c.set_val = off[9:8];
    if (wr) begin
      if (off == OFF_ST_EOI) c.op = PQ_OP_EOI;
    end else begin
      if (off == OFF_LD_EOI)                         c.op = PQ_OP_EOI;
      else if (off[11:10] == 2'b11 && off[7:0] == 8'h00) c.op = PQ_OP_SET;
      else                                           c.op = PQ_OP_GET;
    end
    return c;
  endfunction

endpackage

// File: rtl/evt_pq_decode.sv
module evt_pq_decode
  import evt_pq_pkg::*;
#(
  parameter int NSRC   = 6,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 15
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [NSRC-1:0]   hit,
  output pq_cmd_t           cmd
);

  logic [IDX_W-1:0] page;
  assign page = req_addr[ADDR_W-1:PAGE_BITS];
  assign cmd  = pq_decode(req_write, req_addr[PAGE_BITS-1:0]);

  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hit[i] = req_valid && (page == IDX_W'(i));
  end

endmodule

// File: rtl/evt_pq_cell.sv
module evt_pq_cell
  import evt_pq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  pq_cmd_t    cmd,
  input  logic       trig,
  input  logic       grant,
  output logic [1:0] pq,
  output logic       ntf_req
);

  logic p_q, q_q, pend_q;
  logic p_d, q_d, pend_d, fire;

  always_comb begin
    p_d  = p_q;
    q_d  = q_q;
    fire = 1'b0;
    // software operation first
    if (hit) begin
      unique case (cmd.op)
        PQ_OP_EOI: begin
          if (q_d) begin
            q_d  = 1'b0;
            p_d  = 1'b1;
            fire = 1'b1;
          end else begin
            p_d  = 1'b0;
          end
        end
        PQ_OP_SET: {p_d, q_d} = cmd.set_val;
        default: ;
      endcase
    end
    // then the hardware trigger on the result
    if (trig) begin
      if (!p_d) begin
        p_d  = 1'b1;
        fire = 1'b1;
      end else begin
        q_d  = 1'b1;
      end
    end
    pend_d = p_d & (fire | (pend_q & ~grant));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q    <= 1'b0;
      q_q    <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      p_q    <= p_d;
      q_q    <= q_d;
      pend_q <= pend_d;
    end
  end

  assign pq      = {p_q, q_q};
  assign ntf_req = pend_q;

endmodule

// File: rtl/evt_pq_rr_arb.sv
module evt_pq_rr_arb #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);

  logic [IDX_W-1:0] last_q, lock_idx_q, rr_sel;
  logic             lock_q, rr_found;

  always_comb begin
    int c;
    rr_found = 1'b0;
    rr_sel   = '0;
    for (int k = 1; k <= N; k++) begin
      c = int'(last_q) + k;
      if (c >= N) c = c - N;
      if (!rr_found && req[c]) begin
        rr_found = 1'b1;
        rr_sel   = IDX_W'(c);
      end
    end
  end

  always_comb begin
    if (lock_q) begin
      idx   = lock_idx_q;
      valid = req[lock_idx_q];
    end else begin
      idx   = rr_sel;
      valid = rr_found;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    assign grant[i] = valid && ready && (idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= IDX_W'(N - 1);
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= valid & ~ready;
      lock_idx_q <= idx;
      if (valid && ready) last_q <= idx;
    end
  end

endmodule

// File: rtl/evt_pq_bank.sv
module evt_pq_bank
  import evt_pq_pkg::*;
#(
  parameter int NSRC   = 6,
  parameter int DATA_W = 64,
  localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int ADDR_W = IDX_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_trig,
  input  logic              mmio_valid,
  input  logic              mmio_write,
  input  logic [ADDR_W-1:0] mmio_addr,
  input  logic [DATA_W-1:0] mmio_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [IDX_W-1:0]  ntf_idx
);

  logic [NSRC-1:0]      hit, ntf_req, grant;
  logic [NSRC-1:0][1:0] src_pq;
  pq_cmd_t              cmd;
  logic [1:0]           sel_pq;
  logic                 wdata_unused;

  assign wdata_unused = ^mmio_wdata;

  evt_pq_decode #(.NSRC(NSRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .req_valid (mmio_valid),
    .req_write (mmio_write),
    .req_addr  (mmio_addr),
    .hit       (hit),
    .cmd       (cmd)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    evt_pq_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit[i]),
      .cmd     (cmd),
      .trig    (src_trig[i]),
      .grant   (grant[i]),
      .pq      (src_pq[i]),
      .ntf_req (ntf_req[i])
    );
  end

  evt_pq_rr_arb #(.N(NSRC), .IDX_W(IDX_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ntf_req),
    .ready (ntf_ready),
    .valid (ntf_valid),
    .idx   (ntf_idx),
    .grant (grant)
  );

  always_comb begin
    sel_pq = 2'b00;
    for (int i = 0; i < NSRC; i++) begin
      if (hit[i]) sel_pq = src_pq[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= mmio_valid & ~mmio_write;
      rsp_data  <= (mmio_valid & ~mmio_write) ? DATA_W'(sel_pq) : '0;
    end
  end

endmodule

// File: rtl/evt_pq_bank_chk.sv
module evt_pq_bank_chk #(
  parameter int NSRC   = 6,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC-1:0]      src_trig,
  input logic                 mmio_valid,
  input logic                 mmio_write,
  input logic [ADDR_W-1:0]    mmio_addr,
  input logic                 rsp_valid,
  input logic [DATA_W-1:0]    rsp_data,
  input logic                 ntf_valid,
  input logic                 ntf_ready,
  input logic [IDX_W-1:0]     ntf_idx,
  input logic [NSRC-1:0][1:0] src_pq
);

  // R11
  ntf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> !ntf_valid || $stable(ntf_idx));

  // R13
  ntf_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> src_pq[ntf_idx][1]);

  // R6
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_valid && !mmio_write |=> rsp_valid);

  // R9
  store_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mmio_valid && !mmio_write) |=> !rsp_valid);

  // R6
  rsp_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[DATA_W-1:2] == '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic hit_i;
    assign hit_i = mmio_valid && (mmio_addr[ADDR_W-1:12] == IDX_W'(i));

    // R2
    idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_trig[i] && src_pq[i] == 2'b00 && !hit_i |=> src_pq[i] == 2'b10);

    // R3
    busy_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_trig[i] && src_pq[i][1] && !hit_i |=> src_pq[i] == 2'b11);

    // R7
    get_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i && !mmio_write && mmio_addr[11:0] == 12'h800 && !src_trig[i]
      |=> $stable(src_pq[i]));
  end

endmodule

bind evt_pq_bank evt_pq_bank_chk #(
  .NSRC(NSRC), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_trig   (src_trig),
  .mmio_valid (mmio_valid),
  .mmio_write (mmio_write),
  .mmio_addr  (mmio_addr),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .ntf_valid  (ntf_valid),
  .ntf_ready  (ntf_ready),
  .ntf_idx    (ntf_idx),
  .src_pq     (src_pq)
);

// File: tb/evt_pq_bank_bench.sv
module evt_pq_bank_bench;
  localparam int NSRC = 6, IDX_W = 3, ADDR_W = 15, DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   src_trig = '0;
  logic              mmio_valid = 1'b0, mmio_write = 1'b0;
  logic [ADDR_W-1:0] mmio_addr = '0;
  logic [DATA_W-1:0] mmio_wdata = '0;
  logic              rsp_valid, ntf_valid;
  logic              ntf_ready = 1'b1;
  logic [DATA_W-1:0] rsp_data;
  logic [IDX_W-1:0]  ntf_idx;

  int checks = 0, fails = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_pq_bank #(.NSRC(NSRC), .DATA_W(DATA_W)) u_evt_pq_bank (
    .clk(clk), .rst_n(rst_n), .src_trig(src_trig),
    .mmio_valid(mmio_valid), .mmio_write(mmio_write), .mmio_addr(mmio_addr),
    .mmio_wdata(mmio_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_idx(ntf_idx)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each accepted notification
  initial forever begin
    @(negedge clk);
    #3;
    if (rst_n && ntf_valid && ntf_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected notification", ntf_idx, 64'hFF);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(ntf_idx == IDX_W'(e), "R2 R11 notification index", ntf_idx, e);
      end
    end
  end

  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk);
    src_trig = m;
    @(posedge clk);
    @(negedge clk);
    src_trig = '0;
  endtask

  task automatic op(input bit wr, input int idx, input logic [11:0] off,
                    input logic [NSRC-1:0] tm, input logic [1:0] exp, input string tag);
    @(negedge clk);
    mmio_valid = 1'b1;
    mmio_write = wr;
    mmio_addr  = {IDX_W'(idx), off};
    mmio_wdata = wr ? 64'hA5A5_0000_FFFF_1234 : 64'h0;
    src_trig   = tm;
    @(posedge clk);
    @(negedge clk);
    mmio_valid = 1'b0;
    src_trig   = '0;
    if (wr) chk(!rsp_valid, {tag, " (no response to store)"}, rsp_valid, 0);
    else    chk(rsp_valid && rsp_data == DATA_W'(exp), tag, rsp_data, exp);
  endtask

  task automatic get(input int idx, input logic [1:0] exp, input string tag);
    op(1'b0, idx, 12'h800, '0, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!ntf_valid, "R1 ntf_valid in reset", ntf_valid, 0);
    chk(!rsp_valid, "R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NSRC; i++) get(i, 2'b00, "R1 PQ after reset");

    // R2 idle trigger
    exp_q.push_back(1);
    pulse(6'b000010);
    idle(2);
    get(1, 2'b10, "R2 PQ after trigger");

    // R3 trigger while pending
    pulse(6'b000010);
    idle(2);
    get(1, 2'b11, "R3 Q recorded");

    // R5 load-EOI with Q set
    exp_q.push_back(1);
    op(1'b0, 1, 12'h000, '0, 2'b11, "R5 load-EOI returns old");
    idle(2);
    get(1, 2'b10, "R5 PQ after EOI with Q");

    // R4 store-EOI with Q clear, R9 data ignored
    op(1'b1, 1, 12'h400, '0, 2'b00, "R4 R9 store-EOI");
    get(1, 2'b00, "R4 PQ after EOI");
    op(1'b0, 1, 12'h000, '0, 2'b00, "R4 load-EOI on idle");
    get(1, 2'b00, "R4 idle stays idle");

    // R8 set operations
    op(1'b0, 3, 12'hF00, '0, 2'b00, "R8 set11 returns old");
    get(3, 2'b11, "R8 after set11");
    op(1'b0, 3, 12'hD00, '0, 2'b11, "R8 set01 returns old");
    get(3, 2'b01, "R8 after set01");
    op(1'b0, 3, 12'hE00, '0, 2'b01, "R8 set10 returns old");
    op(1'b0, 3, 12'hC00, '0, 2'b10, "R8 set00 returns old");
    get(3, 2'b00, "R8 after set00");

    // R7 unlisted load offsets
    op(1'b0, 3, 12'hF00, '0, 2'b00, "R7 prep set11");
    op(1'b0, 3, 12'h123, '0, 2'b11, "R7 unlisted load");
    op(1'b0, 3, 12'h400, '0, 2'b11, "R7 load at store offset");
    get(3, 2'b11, "R7 unchanged");
    op(1'b0, 3, 12'hC00, '0, 2'b11, "R7 cleanup");

    // R9 stores
    op(1'b1, 4, 12'hF00, '0, 2'b00, "R9 store at set offset");
    get(4, 2'b00, "R9 store at set offset no effect");
    op(1'b0, 4, 12'hF00, '0, 2'b00, "R9 prep set11");
    exp_q.push_back(4);
    op(1'b1, 4, 12'h400, '0, 2'b00, "R9 R5 store-EOI with Q");
    idle(2);
    get(4, 2'b10, "R9 R5 after store-EOI");
    op(1'b1, 4, 12'h800, '0, 2'b00, "R9 store at get offset");
    get(4, 2'b10, "R9 store no effect");
    op(1'b1, 4, 12'h400, '0, 2'b00, "R9 R4 store-EOI");
    get(4, 2'b00, "R9 R4 idle again");

    // R10 same-cycle operation and trigger
    exp_q.push_back(2);
    pulse(6'b000100);
    idle(2);
    exp_q.push_back(2);
    op(1'b0, 2, 12'h000, 6'b000100, 2'b10, "R10 EOI plus trigger returns old");
    idle(2);
    get(2, 2'b10, "R10 EOI then trigger");
    op(1'b0, 3, 12'hF00, '0, 2'b00, "R10 prep set11");
    exp_q.push_back(3);
    op(1'b0, 3, 12'hC00, 6'b001000, 2'b11, "R10 set00 plus trigger");
    idle(2);
    get(3, 2'b10, "R10 set then trigger");
    op(1'b0, 2, 12'hC00, '0, 2'b10, "R10 cleanup 2");
    op(1'b0, 3, 12'hC00, '0, 2'b10, "R10 cleanup 3");

    // R12 out-of-range index
    op(1'b0, 6, 12'hF00, '0, 2'b00, "R12 set on index 6");
    op(1'b0, 6, 12'h800, '0, 2'b00, "R12 get on index 6");
    op(1'b0, 7, 12'h000, '0, 2'b00, "R12 EOI on index 7");
    get(0, 2'b00, "R12 no aliasing");

    // R13 withdrawal
    @(negedge clk);
    ntf_ready = 1'b0;
    pulse(6'b010000);
    idle(2);
    chk(ntf_valid && ntf_idx == 3'd4, "R13 held notification", {ntf_valid, ntf_idx}, {1'b1, 3'd4});
    op(1'b0, 4, 12'hC00, '0, 2'b10, "R13 clear P");
    chk(!ntf_valid, "R13 notification withdrawn", ntf_valid, 0);
    idle(2);

    // R11 round robin and hold (last accepted index is 3)
    pulse(6'b100101);
    chk(ntf_valid && ntf_idx == 3'd5, "R11 first pick", {ntf_valid, ntf_idx}, {1'b1, 3'd5});
    idle(2);
    chk(ntf_valid && ntf_idx == 3'd5, "R11 index held", {ntf_valid, ntf_idx}, {1'b1, 3'd5});
    exp_q.push_back(5);
    exp_q.push_back(0);
    exp_q.push_back(2);
    @(negedge clk);
    ntf_ready = 1'b1;
    idle(6);
    chk(!ntf_valid, "R11 all served", ntf_valid, 0);

    chk(exp_q.size() == 0, "R2 R11 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule